// File: doc/BRIEF.md
# Self-Synchronising Serial Scrambler and Descrambler

This block holds the two ends of a serial scrambled link and a line-error counter. The transmit side takes one data bit per valid cycle and XORs it with the line bit it sent a fixed number of valid bits earlier. The multiplier is x^43 + 1, so the lag is 43. The scrambled bit goes out registered, and a valid strobe marks each line bit.

The receive side always shifts the raw received line bit into its history register. It never shifts in its own result, so it needs no alignment step and no lock state machine. Once it has seen 43 valid bits that carry no error, its output equals the data that was sent. The cost is error spreading: one corrupted line bit gives one wrong output bit for each nonzero term of the polynomial. Here that is two.

For line testing, the transmitter can force its data to zero, so the raw sequence goes onto the line. The receiver then counts the descrambled ones. That count divided by two estimates the number of line bit errors. The counter saturates and has a synchronous clear.

Top module: `ssync_link_pair`

## Requirements
- R1: After reset, line_vld_o, rx_vld_o and err_cnt_o are zero, and both history registers are cleared. As a result, the first 43 scrambled bits equal their data bits.
- R2: For each cycle with tx_vld_i high, line_bit_o on the next cycle equals the data bit XOR the line bit sent 43 valid bits earlier. line_vld_o is high on the cycle after tx_vld_i is high and low otherwise.
- R3: While tx_zero_i is high, the data bit is taken as 0 whatever tx_dat_i is, so the line carries the raw sequence.
- R4: For each cycle with rx_vld_i high, rx_dat_o on the next cycle equals rx_bit_i XOR the received bit 43 valid bits earlier.
- R5: rx_vld_o rises one cycle after a valid received bit, and only when at least 43 valid bits were shifted in before that bit since reset.
- R6: After 43 error-free line bits, rx_dat_o equals the transmitted data, whatever the receiver history held before.
- R7: A cycle with its valid input low shifts neither history register.
- R8: In the all-zeros mode, one flipped line bit produces exactly two descrambled ones, 43 valid bits apart.
- R9: err_cnt_o increases by one, in the same cycle as rx_dat_o updates, for each valid descrambled bit that is 1 while rx_cnt_en_i is high. It does not change otherwise.
- R10: err_cnt_o stops at all ones and does not wrap. The width is the CNT_W parameter, default 32.
- R11: err_clr_i high zeroes err_cnt_o at the next edge and takes priority over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_vld_i | input | 1 | Transmit data bit valid |
| tx_dat_i | input | 1 | Transmit data bit |
| tx_zero_i | input | 1 | Force transmit data to zero (test mode) |
| line_vld_o | output | 1 | Scrambled line bit valid |
| line_bit_o | output | 1 | Scrambled line bit |
| rx_vld_i | input | 1 | Received line bit valid |
| rx_bit_i | input | 1 | Received line bit |
| rx_cnt_en_i | input | 1 | Count descrambled ones as errors |
| err_clr_i | input | 1 | Synchronous clear of the error counter |
| rx_vld_o | output | 1 | Descrambled bit valid |
| rx_dat_o | output | 1 | Descrambled bit |
| err_cnt_o | output | CNT_W | Saturating count of descrambled ones |

## Verification
The bench first feeds the receiver unrelated bits, then plays in a freshly scrambled stream. A design that fed its own feedback back into the history would never recover the data. One that was off by one in the lag would match for nothing after bit 43.

The 43-bit fill boundary is checked on both sides. A counter starting one bit early would show a valid output built from reset zeros. A single injected line error must cost exactly two counts, which catches a missing or extra tap.

The counter runs with a narrow width, so a counter that wraps returns to small values. The bench also asserts clear and increment in the same cycle, so a design that lets the increment win shows a nonzero count.

// File: rtl/ssync_pkg.sv
package ssync_pkg;
   localparam int unsigned SSYNC_LAG_DEF = 43;
   localparam int unsigned SSYNC_CNT_DEF = 32;

   function automatic int unsigned fill_width(input int unsigned lag);
      return $clog2(lag + 1);
   endfunction
endpackage

// File: rtl/ssync_hist.sv
module ssync_hist #(
   parameter int unsigned LAG = 43
) (
   input  logic clk,
   input  logic rst_n,
   input  logic shift_i,
   input  logic bit_i,
   output logic old_o
);
   logic [LAG-1:0] stg;

   for (genvar g = 0; g < LAG; g++) begin : g_stage
      if (g == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n)       stg[0] <= 1'b0;
            else if (shift_i) stg[0] <= bit_i;
         end
      end else begin : g_body
         always_ff @(posedge clk) begin
            if (!rst_n)       stg[g] <= 1'b0;
            else if (shift_i) stg[g] <= stg[g-1];
         end
      end
   end

   assign old_o = stg[LAG-1];

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_i |=> $stable(stg));
endmodule

// File: rtl/ssync_scrambler.sv
module ssync_scrambler #(
   parameter int unsigned LAG = 43
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic dat_i,
   input  logic zero_i,
   output logic vld_o,
   output logic bit_o
);
   logic data_eff, old_bit, scr_bit;

   assign data_eff = zero_i ? 1'b0 : dat_i;
   assign scr_bit  = data_eff ^ old_bit;

   ssync_hist #(.LAG(LAG)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift_i(vld_i), .bit_i(scr_bit), .old_o(old_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         bit_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) bit_o <= scr_bit;
      end
   end

   // R2
   line_vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_i |=> vld_o);
   // R7
   line_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_i |=> !vld_o);
endmodule

// File: rtl/ssync_descrambler.sv
module ssync_descrambler #(
   parameter int unsigned LAG = 43
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vld_i,
   input  logic bit_i,
   output logic hit_o,
   output logic vld_o,
   output logic dat_o
);
   import ssync_pkg::*;
   localparam int unsigned FW = fill_width(LAG);
   localparam logic [FW-1:0] FULL = FW'(LAG);

   logic [FW-1:0] fill_q;
   logic          old_bit, dsc_bit, filled;

   ssync_hist #(.LAG(LAG)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift_i(vld_i), .bit_i(bit_i), .old_o(old_bit)
   );

   assign dsc_bit = bit_i ^ old_bit;
   assign filled  = (fill_q == FULL);
   assign hit_o   = vld_i & filled & dsc_bit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill_q <= '0;
         vld_o  <= 1'b0;
         dat_o  <= 1'b0;
      end else begin
         vld_o <= vld_i & filled;
         if (vld_i) begin
            dat_o <= dsc_bit;
            if (!filled) fill_q <= fill_q + 1'b1;
         end
      end
   end

   // R5
   rx_vld_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> (fill_q == FULL));
   // R5
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FULL);
endmodule

// File: rtl/ssync_errcnt.sv
module ssync_errcnt #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             hit_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n)                               cnt_o <= '0;
      else if (clr_i)                           cnt_o <= '0;
      else if (en_i && hit_i && (cnt_o != TOP)) cnt_o <= cnt_o + 1'b1;
   end

   // R10
   cnt_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> (cnt_o >= $past(cnt_o)));
   // R9
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_i |=> ({1'b0, cnt_o} <= ({1'b0, $past(cnt_o)} + 1'b1)));
   // R11
   cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0));
   // R9
   cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !en_i) |=> $stable(cnt_o));
endmodule

// File: rtl/ssync_link_pair.sv
module ssync_link_pair #(
   parameter int unsigned LAG   = ssync_pkg::SSYNC_LAG_DEF,
   parameter int unsigned CNT_W = ssync_pkg::SSYNC_CNT_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_vld_i,
   input  logic             tx_dat_i,
   input  logic             tx_zero_i,
   output logic             line_vld_o,
   output logic             line_bit_o,
   input  logic             rx_vld_i,
   input  logic             rx_bit_i,
   input  logic             rx_cnt_en_i,
   input  logic             err_clr_i,
   output logic             rx_vld_o,
   output logic             rx_dat_o,
   output logic [CNT_W-1:0] err_cnt_o
);
   if (LAG < 2) begin : g_bad_lag
      $error("ssync_link_pair: LAG must be at least 2");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("ssync_link_pair: CNT_W must be at least 2");
   end

   logic rx_hit;

   ssync_scrambler #(.LAG(LAG)) u_scr (
      .clk(clk), .rst_n(rst_n), .vld_i(tx_vld_i), .dat_i(tx_dat_i),
      .zero_i(tx_zero_i), .vld_o(line_vld_o), .bit_o(line_bit_o)
   );

   ssync_descrambler #(.LAG(LAG)) u_dsc (
      .clk(clk), .rst_n(rst_n), .vld_i(rx_vld_i), .bit_i(rx_bit_i),
      .hit_o(rx_hit), .vld_o(rx_vld_o), .dat_o(rx_dat_o)
   );

   ssync_errcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(rx_cnt_en_i), .hit_i(rx_hit),
      .clr_i(err_clr_i), .cnt_o(err_cnt_o)
   );

   // R1
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> (!line_vld_o && !rx_vld_o && (err_cnt_o == '0)));
endmodule

// File: tb/sim_ssync_link_pair.sv
module sim_ssync_link_pair;
   localparam int LAG = 43;
   localparam int CW  = 4;
   localparam logic [CW-1:0] TOPV = {CW{1'b1}};

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_vld = 0, tx_dat = 0, tx_zero = 0;
   logic rx_vld = 0, rx_bit = 0, rx_cen = 0, clr = 0;
   logic line_vld, line_bit, rx_vldo, rx_dat;
   logic [CW-1:0] err_cnt;

   int checks = 0, fails = 0;
   bit done = 0;

   logic [LAG-1:0] th = '0, rh = '0;
   int fill = 0;
   logic e_lvld = 0, e_lbit = 0, e_rvld = 0, e_rdat = 0;
   logic [CW-1:0] e_cnt = '0;

   always #5 clk = ~clk;

   ssync_link_pair #(.LAG(LAG), .CNT_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .tx_vld_i(tx_vld), .tx_dat_i(tx_dat),
      .tx_zero_i(tx_zero), .line_vld_o(line_vld), .line_bit_o(line_bit),
      .rx_vld_i(rx_vld), .rx_bit_i(rx_bit), .rx_cnt_en_i(rx_cen),
      .err_clr_i(clr), .rx_vld_o(rx_vldo), .rx_dat_o(rx_dat), .err_cnt_o(err_cnt)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic scr_bit(input logic d, input logic z, input logic [LAG-1:0] h);
      return (z ? 1'b0 : d) ^ h[LAG-1];
   endfunction

   task automatic step(input logic tv, input logic td, input logic tz,
                       input logic rv, input logic rb, input logic rc, input logic cl);
      @(negedge clk);
      tx_vld = tv; tx_dat = td; tx_zero = tz;
      rx_vld = rv; rx_bit = rb; rx_cen = rc; clr = cl;
      @(posedge clk);
      e_lvld = tv;
      if (tv) begin
         e_lbit = scr_bit(td, tz, th);
         th = {th[LAG-2:0], e_lbit};
      end
      e_rvld = rv && (fill >= LAG);
      if (rv) begin
         logic o;
         o = rb ^ rh[LAG-1];
         if (cl) e_cnt = '0;
         else if (rc && fill >= LAG && o && e_cnt != TOPV) e_cnt = e_cnt + 1'b1;
         e_rdat = o;
         rh = {rh[LAG-2:0], rb};
         if (fill < LAG) fill++;
      end else if (cl) e_cnt = '0;
      #1;
      chk(line_vld == e_lvld, "R2 line_vld", line_vld, e_lvld);
      if (e_lvld) chk(line_bit == e_lbit, "R2/R3 line_bit", line_bit, e_lbit);
      chk(rx_vldo == e_rvld, "R5 rx_vld", rx_vldo, e_rvld);
      if (e_rvld) chk(rx_dat == e_rdat, "R4 rx_dat", rx_dat, e_rdat);
      chk(err_cnt == e_cnt, "R9/R10/R11 err_cnt", err_cnt, e_cnt);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int seed_dummy;
      logic dd [200];
      logic ll [200];
      logic [LAG-1:0] h;
      seed_dummy = $urandom(32'h5eed_1234);
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(line_vld == 0, "R1 line_vld reset", line_vld, 0);
      chk(rx_vldo == 0, "R1 rx_vld reset", rx_vldo, 0);
      chk(err_cnt == 0, "R1 err_cnt reset", err_cnt, 0);
      @(negedge clk); rst_n = 1;

      // R1/R5: first 43 line bits equal data; receiver not valid until the 44th bit
      for (int i = 0; i < LAG; i++) begin
         logic d;
         d = 1'($urandom);
         step(1, d, 0, 1, 1'($urandom), 1, 0);
         chk(line_bit == d, "R1 cleared history", line_bit, d);
         chk(rx_vldo == 0, "R5 fill boundary low", rx_vldo, 0);
      end
      step(0, 0, 0, 1, 1, 0, 0);
      chk(rx_vldo == 1, "R5 fill boundary high", rx_vldo, 1);

      // Random phase: R2 R3 R4 R7 R9 R11
      for (int i = 0; i < 3000; i++)
         step(1'($urandom), 1'($urandom), ($urandom % 4) == 0,
              ($urandom % 3) != 0, 1'($urandom), 1'($urandom), ($urandom % 64) == 0);

      // R3: zero mode ignores data; with fresh history the line is raw sequence
      for (int i = 0; i < 60; i++) begin
         logic exp_b;
         exp_b = th[LAG-1];
         step(1, 1, 1, 0, 0, 0, 0);
         chk(line_bit == exp_b, "R3 zero mode", line_bit, exp_b);
      end

      // R6: self synchronisation from an arbitrary receiver state
      h = LAG'({$urandom, $urandom});
      for (int i = 0; i < 200; i++) begin
         dd[i] = 1'($urandom);
         ll[i] = dd[i] ^ h[LAG-1];
         h = {h[LAG-2:0], ll[i]};
      end
      for (int i = 0; i < 200; i++) begin
         step(0, 0, 0, 1, ll[i], 0, 0);
         if (i >= LAG) chk(rx_dat == dd[i], "R6 self sync", rx_dat, dd[i]);
         if ((i % 5) == 0) step(0, 0, 0, 0, 0, 0, 0); // R7 gaps
      end

      // R8: one line error gives two counts
      for (int i = 0; i < LAG; i++) step(0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < 100; i++) step(0, 0, 0, 1, (i == 10), 1, 0);
      chk(err_cnt == 2, "R8 single error spread", err_cnt, 2);

      // R9: counting disabled leaves the count
      for (int i = 0; i < 20; i++) step(0, 0, 0, 1, 1'($urandom), 0, 0);
      chk(err_cnt == 2, "R9 count disabled", err_cnt, 2);

      // R10: saturation
      step(0, 0, 0, 0, 0, 0, 1);
      for (int i = 0; i < LAG; i++) step(0, 0, 0, 1, 0, 0, 0);
      for (int i = 0; i < 30; i++) step(0, 0, 0, 1, 1, 1, 0);
      chk(err_cnt == TOPV, "R10 saturate", err_cnt, TOPV);

      // R11: clear beats increment
      step(0, 0, 0, 1, 1, 1, 1);
      chk(err_cnt == 0, "R11 clear priority", err_cnt, 0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule